// File: doc/BRIEF.md
# Packet Byte Buffer with Status Flags

This block is the byte store that sits between a radio packet engine and the host register file. The packet engine pushes received bytes one per cycle; the host pops them through a register-read strobe. The oldest stored byte is always visible on the read-data port. An empty buffer shows zero on that port.

Alongside the store, the block keeps one eight-bit flag word. Three bits follow the fill count: full, not-empty and above-threshold. The other bits are sticky. An overrun bit records a dropped write. A payload-ready bit and a CRC-good bit are raised by the packet engine at the end of a packet, and both fall away by themselves once the buffer is drained. A low-battery bit latches a supply-monitor event. Writing a one to the overrun position resets the whole store so that a fresh reception can start at once.

Top module: `pkt_fifo_status`

## Requirements
- R1: After reset, `flags_o` is 0x00 and `rd_data_o` is 0x00.
- R2: Flag bit 7 (full) is 1 exactly when 66 bytes are stored (DEPTH default). Flag bit 6 (not-empty) is 1 whenever at least one byte is stored.
- R3: Flag bit 5 (level) is 1 only when the stored count is strictly greater than `level_thresh_i`.
- R4: Bytes leave in the order they were pushed. `rd_data_o` shows the oldest stored byte, and `host_rd_i` removes it.
- R5: A pop while the buffer is empty is ignored. `rd_data_o` reads 0x00, and the count and order of later bytes are unchanged.
- R6: A push while the buffer is full, with no pop in the same cycle, is discarded. It sets flag bit 4 (overrun), and that bit stays set until it is cleared. No overrun is recorded while `sleep_i` is high.
- R7: A push and a pop in the same cycle while the buffer is full are both accepted. The count stays at 66 and overrun is not set.
- R8: A flag write with bit 4 = 1 empties the buffer and clears bits 4, 2 and 1. A push in that same cycle is discarded. A flag write with bit 4 = 0 leaves the buffer and bits 4, 2 and 1 untouched.
- R9: Flag bit 2 (payload-ready) is set by `payload_done_i` only while `rx_mode_i` is high, and only when one of these holds: `crc_en_i` is low, `crc_keep_i` is high, or `crc_good_i` is high.
- R10: Flag bit 1 (CRC-good) is set by `payload_done_i` while `rx_mode_i` and `crc_good_i` are both high.
- R11: Flag bits 2 and 1 are cleared in the cycle the buffer becomes empty.
- R12: Flag bit 3 always reads 0. Flag bit 0 (low-battery) is set by `lowbat_i` and is cleared only by a flag write with bit 0 = 1. A flag write that clears overrun does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Device in sleep mode; suppresses overrun |
| rx_mode_i | input | 1 | Device in receive mode |
| eng_wr_i | input | 1 | Packet engine push strobe |
| eng_data_i | input | 8 | Byte to push |
| host_rd_i | input | 1 | Host pop strobe |
| rd_data_o | output | 8 | Oldest stored byte, zero when empty |
| level_thresh_i | input | 7 | Threshold for the level flag |
| payload_done_i | input | 1 | Last payload byte received |
| crc_en_i | input | 1 | CRC checking enabled |
| crc_keep_i | input | 1 | Deliver payload even when the CRC fails |
| crc_good_i | input | 1 | CRC of the payload matched |
| lowbat_i | input | 1 | Low-battery event |
| flag_wr_i | input | 1 | Host write strobe to the flag word |
| flag_wdata_i | input | 8 | Flag write data (ones clear bits 4 and 0) |
| flags_o | output | 8 | Flag word: 7 full, 6 not-empty, 5 level, 4 overrun, 3 zero, 2 payload-ready, 1 CRC-good, 0 low-battery |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a push and a pop while the buffer is full. The second pair is an engine push and the host's overrun-clear write. The bench first fills the store to 66 bytes, then issues a push together with a pop. It judges the outcome by three things: the full flag stays up, the overrun bit stays down, and the head advances by one. Separately, it issues an overrun-clear write in the same cycle as an engine push. It expects an empty buffer with all flags down, which shows that the flush took priority over the push.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    // Bit positions inside the host-visible flag word
    localparam int unsigned FB_FULL   = 7;
    localparam int unsigned FB_NEMPTY = 6;
    localparam int unsigned FB_LEVEL  = 5;
    localparam int unsigned FB_OVR    = 4;
    localparam int unsigned FB_PREADY = 2;
    localparam int unsigned FB_CRCOK  = 1;
    localparam int unsigned FB_LOWBAT = 0;

    typedef struct packed {
        logic ovr;
        logic pready;
        logic crcok;
        logic lowbat;
    } sticky_t;

endpackage

// File: rtl/pfs_store.sv
module pfs_store #(
    parameter int unsigned DEPTH = 66,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    input  logic             flush_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             drop_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } ptr_st_t;

    ptr_st_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];

    logic empty, full, pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt == CNT_W'(DEPTH));
        pop_ok  = pop_i && !empty && !flush_i;
        push_ok = push_i && !flush_i && (!full || pop_ok);
        drop_o  = push_i && !flush_i && full && !pop_ok;

        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wptr = wrap_inc(st_q.wptr);
            if (pop_ok)  st_d.rptr = wrap_inc(st_q.rptr);
            st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wptr] <= data_i;
    end

    assign head_o     = empty ? '0 : mem_q[st_q.rptr];
    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R7
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && pop_i && !flush_i) |=> (st_q.cnt == CNT_W'(DEPTH)));

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_i && !pop_i && !flush_i) |=> (st_q.cnt == CNT_W'(DEPTH) && $stable(st_q.rptr)));

    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_i && !push_i && !flush_i) |=> (st_q.cnt == '0 && $stable(st_q.rptr)));

    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.cnt == '0));

endmodule

// File: rtl/pfs_flags.sv
module pfs_flags
    import pfs_pkg::*;
#(
    parameter int unsigned DEPTH = 66,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic             sleep_i,
    input  logic             rx_mode_i,
    input  logic             drop_i,
    input  logic             payload_done_i,
    input  logic             crc_en_i,
    input  logic             crc_keep_i,
    input  logic             crc_good_i,
    input  logic             lowbat_i,
    input  logic             flag_wr_i,
    input  logic [7:0]       flag_wdata_i,
    output logic             flush_o,
    output logic [7:0]       flags_o
);

    sticky_t st_d, st_q;
    logic pready_set, crcok_set, lowbat_clr, keeps_data;
    logic unused_wbits;

    assign unused_wbits = ^{flag_wdata_i[7:5], flag_wdata_i[3:1]};

    always_comb begin
        flush_o    = flag_wr_i && flag_wdata_i[FB_OVR];
        lowbat_clr = flag_wr_i && flag_wdata_i[FB_LOWBAT];
        keeps_data = (cnt_next_i != '0);
        pready_set = payload_done_i && rx_mode_i && (!crc_en_i || crc_keep_i || crc_good_i);
        crcok_set  = payload_done_i && rx_mode_i && crc_good_i;

        st_d        = st_q;
        st_d.lowbat = lowbat_i || (st_q.lowbat && !lowbat_clr);
        if (flush_o) begin
            st_d.ovr    = 1'b0;
            st_d.pready = 1'b0;
            st_d.crcok  = 1'b0;
        end else begin
            st_d.ovr    = st_q.ovr || (drop_i && !sleep_i);
            st_d.pready = (st_q.pready || pready_set) && keeps_data;
            st_d.crcok  = (st_q.crcok || crcok_set) && keeps_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags_o            = '0;
        flags_o[FB_FULL]   = (cnt_i == CNT_W'(DEPTH));
        flags_o[FB_NEMPTY] = (cnt_i != '0);
        flags_o[FB_LEVEL]  = (cnt_i > thresh_i);
        flags_o[FB_OVR]    = st_q.ovr;
        flags_o[FB_PREADY] = st_q.pready;
        flags_o[FB_CRCOK]  = st_q.crcok;
        flags_o[FB_LOWBAT] = st_q.lowbat;
    end

    // R11
    drained_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i == '0) |-> (!st_q.pready && !st_q.crcok));

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !flush_o) |=> st_q.ovr);

    // R6
    sleep_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ovr && drop_i && sleep_i) |=> !st_q.ovr);

    // R12
    lowbat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lowbat && !lowbat_clr) |=> st_q.lowbat);

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (!st_q.ovr && !st_q.pready && !st_q.crcok));

endmodule

// File: rtl/pkt_fifo_status.sv
module pkt_fifo_status #(
    parameter int unsigned DEPTH = 66,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_i,
    input  logic             rx_mode_i,
    input  logic             eng_wr_i,
    input  logic [7:0]       eng_data_i,
    input  logic             host_rd_i,
    output logic [7:0]       rd_data_o,
    input  logic [CNT_W-1:0] level_thresh_i,
    input  logic             payload_done_i,
    input  logic             crc_en_i,
    input  logic             crc_keep_i,
    input  logic             crc_good_i,
    input  logic             lowbat_i,
    input  logic             flag_wr_i,
    input  logic [7:0]       flag_wdata_i,
    output logic [7:0]       flags_o
);

    logic [CNT_W-1:0] cnt, cnt_next;
    logic             drop, flush;

    pfs_store #(.DEPTH(DEPTH), .WIDTH(8)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (eng_wr_i),
        .data_i     (eng_data_i),
        .pop_i      (host_rd_i),
        .flush_i    (flush),
        .head_o     (rd_data_o),
        .cnt_o      (cnt),
        .cnt_next_o (cnt_next),
        .drop_o     (drop)
    );

    pfs_flags #(.DEPTH(DEPTH)) i_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .cnt_i          (cnt),
        .cnt_next_i     (cnt_next),
        .thresh_i       (level_thresh_i),
        .sleep_i        (sleep_i),
        .rx_mode_i      (rx_mode_i),
        .drop_i         (drop),
        .payload_done_i (payload_done_i),
        .crc_en_i       (crc_en_i),
        .crc_keep_i     (crc_keep_i),
        .crc_good_i     (crc_good_i),
        .lowbat_i       (lowbat_i),
        .flag_wr_i      (flag_wr_i),
        .flag_wdata_i   (flag_wdata_i),
        .flush_o        (flush),
        .flags_o        (flags_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[6] == 1'b0) |-> (rd_data_o == 8'h00));

endmodule

// File: tb/test_pkt_fifo_status.sv
`timescale 1ns/1ps
module test_pkt_fifo_status;

    logic clk = 0, rst_n = 0;
    logic sleep_i = 0, rx_mode_i = 0, eng_wr_i = 0, host_rd_i = 0;
    logic [7:0] eng_data_i = 0, flag_wdata_i = 0;
    logic [6:0] level_thresh_i = 7'd2;
    logic payload_done_i = 0, crc_en_i = 0, crc_keep_i = 0, crc_good_i = 0;
    logic lowbat_i = 0, flag_wr_i = 0;
    logic [7:0] rd_data_o, flags_o;

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    pkt_fifo_status i_pkt_fifo_status (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .rx_mode_i(rx_mode_i),
        .eng_wr_i(eng_wr_i), .eng_data_i(eng_data_i), .host_rd_i(host_rd_i),
        .rd_data_o(rd_data_o), .level_thresh_i(level_thresh_i),
        .payload_done_i(payload_done_i), .crc_en_i(crc_en_i), .crc_keep_i(crc_keep_i),
        .crc_good_i(crc_good_i), .lowbat_i(lowbat_i), .flag_wr_i(flag_wr_i),
        .flag_wdata_i(flag_wdata_i), .flags_o(flags_o)
    );

    // {push, pop, data, expected flags, expected head}
    localparam logic [25:0] VEC [10] = '{
        {1'b1, 1'b0, 8'hA1, 8'h40, 8'hA1},
        {1'b1, 1'b0, 8'hB2, 8'h40, 8'hA1},
        {1'b1, 1'b0, 8'hC3, 8'h60, 8'hA1},
        {1'b0, 1'b1, 8'h00, 8'h40, 8'hB2},
        {1'b1, 1'b1, 8'hD4, 8'h40, 8'hC3},
        {1'b0, 1'b1, 8'h00, 8'h40, 8'hD4},
        {1'b0, 1'b1, 8'h00, 8'h00, 8'h00},
        {1'b0, 1'b1, 8'h00, 8'h00, 8'h00},
        {1'b1, 1'b0, 8'hE5, 8'h40, 8'hE5},
        {1'b0, 1'b1, 8'h00, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input logic psh, input logic pp, input logic [7:0] d);
        eng_wr_i = psh; host_rd_i = pp; eng_data_i = d;
        @(posedge clk); #1;
        eng_wr_i = 0; host_rd_i = 0; payload_done_i = 0; lowbat_i = 0; flag_wr_i = 0;
    endtask

    task automatic flag_write(input logic [7:0] v, input logic psh, input logic [7:0] d);
        flag_wr_i = 1; flag_wdata_i = v;
        step(psh, 0, d);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
    endtask

    task automatic fill();
        for (int i = 0; i < 66; i++) step(1, 0, 8'(i + 1));
    endtask

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        do_reset();
        // R1 reset state
        chk("R1 flags", flags_o, 8'h00);
        chk("R1 head", rd_data_o, 8'h00);

        // R2 R3 R4 R5 vector walk
        foreach (VEC[k]) begin
            step(VEC[k][25], VEC[k][24], VEC[k][23:16]);
            chk($sformatf("R2/R3 flags vec%0d", k), flags_o, VEC[k][15:8]);
            chk($sformatf("R4/R5 head vec%0d", k), rd_data_o, VEC[k][7:0]);
        end

        // R2 full, R12 bit3
        fill();
        chk("R2 full flags", flags_o, 8'hE0);
        chk("R12 bit3 zero", {7'd0, flags_o[3]}, 8'h00);
        // R6 push while full
        step(1, 0, 8'h77);
        chk("R6 overrun", flags_o, 8'hF0);
        chk("R6 head kept", rd_data_o, 8'h01);
        // R8 clear overrun with a simultaneous push
        flag_write(8'h10, 1, 8'h55);
        chk("R8 flush flags", flags_o, 8'h00);
        chk("R8 flush head", rd_data_o, 8'h00);

        // R6 sleep suppresses overrun
        fill();
        sleep_i = 1;
        step(1, 0, 8'h88);
        sleep_i = 0;
        chk("R6 sleep no overrun", flags_o, 8'hE0);
        // R7 push and pop at full
        step(1, 1, 8'h99);
        chk("R7 full swap flags", flags_o, 8'hE0);
        chk("R7 head advanced", rd_data_o, 8'h02);
        for (int i = 0; i < 64; i++) step(0, 1, 8'h00);
        chk("R4 order near end", rd_data_o, 8'h42);
        chk("R3 count equals thresh", flags_o, 8'h40);
        step(0, 1, 8'h00);
        chk("R7 swapped byte last", rd_data_o, 8'h99);
        step(0, 1, 8'h00);
        chk("R2 empty", flags_o, 8'h00);

        // R8 write without bit 4
        step(1, 0, 8'h31);
        flag_write(8'hEE, 0, 8'h00);
        chk("R8 no flush flags", flags_o, 8'h40);
        chk("R8 no flush head", rd_data_o, 8'h31);

        // R9 R10 payload-ready and CRC-good
        rx_mode_i = 1; crc_en_i = 1; crc_good_i = 0; crc_keep_i = 0;
        payload_done_i = 1; step(1, 0, 8'h32);
        chk("R9 bad crc blocks ready", flags_o, 8'h40);
        crc_good_i = 1; payload_done_i = 1; step(1, 0, 8'h33);
        chk("R9/R10 good crc", flags_o, 8'h66);
        crc_good_i = 0;
        step(0, 1, 8'h00); step(0, 1, 8'h00);
        chk("R11 held while nonempty", flags_o, 8'h46);
        step(0, 1, 8'h00);
        chk("R11 cleared on drain", flags_o, 8'h00);
        crc_keep_i = 1; payload_done_i = 1; step(1, 0, 8'h34);
        chk("R9 keep on bad crc", flags_o, 8'h44);
        crc_keep_i = 0;
        flag_write(8'h10, 0, 8'h00);
        chk("R8 flush clears ready", flags_o, 8'h00);
        rx_mode_i = 0; crc_en_i = 0; payload_done_i = 1; step(1, 0, 8'h35);
        chk("R9 not in rx", flags_o, 8'h40);
        rx_mode_i = 1; payload_done_i = 1; step(0, 0, 8'h00);
        chk("R9 crc disabled", flags_o, 8'h44);

        // R12 low battery
        lowbat_i = 1; step(0, 0, 8'h00);
        chk("R12 lowbat set", flags_o, 8'h45);
        flag_write(8'h10, 0, 8'h00);
        chk("R12 kept by overrun clear", flags_o, 8'h01);
        flag_write(8'hFE, 0, 8'h00);
        chk("R12 kept by bit0=0", flags_o, 8'h01);
        flag_write(8'h01, 0, 8'h00);
        chk("R12 cleared", flags_o, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule